// File: doc/BRIEF.md
# Accumulator Processor Fetch-Execute Controller

This block is a small multi-cycle processor built around a single accumulator. Program words and operand data share one memory and one address space. The processor reaches that memory through one port, which carries an address, a read strobe, a write strobe, write data and read data. Internally it holds five registers: a program counter, a memory address register, a memory data register, an instruction register and the accumulator. A state machine moves the processor through fetch, decode and execute, and each state performs one register transfer.

All memory traffic is staged through the address and data registers. The address output is always the memory address register. Write data is always the memory data register. A word read from memory is first captured in the memory data register, and only then copied onward. The memory port is a fixed-latency strobe interface rather than a stream: read data is valid in the cycle after the read strobe, and there is no back-pressure. A halt instruction parks the machine until reset. Debug outputs expose every register, so that a host or a bench can follow execution.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is active and in the first cycle after it, the program counter, address register, data register, instruction register and accumulator are all zero, both strobes are low, and the halt flag is low.
- R2: Each fetch copies the program counter into the address register and then increments the program counter by one, modulo 4096. After the fetch, the instruction register holds the memory word found at the old program counter.
- R3: The address output always equals the address register, and the read and write strobes are never high in the same cycle.
- R4: An instruction is 16 bits wide. Bits 15:12 hold the opcode and bits 11:0 hold the operand address. The opcodes are 0 = halt, 1 = load, 2 = store, 3 = add and 4 = subtract. During execution, the address register takes bits 11:0 of the instruction register.
- R5: Load sets the accumulator to the memory word at the operand address.
- R6: Add sets the accumulator to the accumulator plus the operand word, modulo 2^16.
- R7: Subtract sets the accumulator to the accumulator minus the operand word, modulo 2^16.
- R8: Store copies the accumulator into the data register and then raises the write strobe for exactly one cycle, with write data equal to the accumulator and the address equal to the operand address. The accumulator does not change. A stored word can later be fetched as an instruction.
- R9: After a halt is decoded, the halt flag stays high until reset. Both strobes stay low and no register changes.
- R10: Opcodes 5 to 15 act as no-ops. They cause no memory access beyond the fetch, leave the accumulator unchanged, and let execution continue at the next word.
- R11: Read data reaches the accumulator only through the data register. The accumulator never changes at the edge that follows a read-strobe cycle, nor at the edge after that.
- R12: Start with the program counter at 50, word 50 holding add 101 (0x3065), word 101 holding 96, and the accumulator at 0. After that instruction completes, the program counter is 51, the address register is 101, the data register is 96 and the accumulator is 96.
- R13: Fetch plus decode takes 6 cycles. Load, add and subtract each take 4 more cycles, and store takes 3 more. The memory returns read data in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory address (the address register) |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (the data register) |
| mem_rdata | input | 16 | Read data from synchronous memory |
| halted | output | 1 | High once a halt has been decoded, until reset |
| dbg_pc | output | 12 | Program counter |
| dbg_mar | output | 12 | Memory address register |
| dbg_mdr | output | 16 | Memory data register |
| dbg_cir | output | 16 | Current instruction register |
| dbg_acc | output | 16 | Accumulator |

## Verification
The assertions take for granted a memory that returns the addressed word exactly one cycle after each read strobe, that commits a write at the edge closing the strobe cycle, and that never drives mem_rdata from anywhere other than its own contents. The stimulus keeps within this by modelling the memory in the bench as an array behind exactly that timing. Reset is held from time zero, so that no property sees undefined register values. The program runs no-op fillers into the fixed add trace, then a wrapping arithmetic chain. A store then overwrites a halt with a no-op, so the halt that ends the run lies further on.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int unsigned OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_HALT  = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4
  } opcode_e;

  typedef enum logic [3:0] {
    S_F_MAR, S_F_INC, S_F_RD, S_F_CAP, S_F_CIR, S_DEC,
    S_X_MAR, S_X_RD, S_X_CAP, S_X_ALU, S_X_MDR, S_X_WR, S_HALT
  } state_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    mar_from_pc;
    logic    mar_from_cir;
    logic    pc_inc;
    logic    mdr_from_mem;
    logic    mdr_from_acc;
    logic    cir_load;
    logic    acc_load;
    alu_op_e alu_op;
    logic    rd;
    logic    wr;
  } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu import acc_cpu_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    unique case (op)
      ALU_ADD:  result = acc_in + opnd;
      ALU_SUB:  result = acc_in - opnd;
      default:  result = opnd;
    endcase
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl import acc_cpu_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output ctl_t             ctl,
  output logic             halted
);
  state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_F_MAR;
    else        state_q <= state_d;
  end

  always_comb begin
    ctl     = '0;
    state_d = state_q;
    unique case (state_q)
      S_F_MAR: begin ctl.mar_from_pc  = 1'b1; state_d = S_F_INC; end
      S_F_INC: begin ctl.pc_inc       = 1'b1; state_d = S_F_RD;  end
      S_F_RD:  begin ctl.rd           = 1'b1; state_d = S_F_CAP; end
      S_F_CAP: begin ctl.mdr_from_mem = 1'b1; state_d = S_F_CIR; end
      S_F_CIR: begin ctl.cir_load     = 1'b1; state_d = S_DEC;   end
      S_DEC: begin
        case (opcode)
          OP_HALT:                          state_d = S_HALT;
          OP_LOAD, OP_STORE, OP_ADD, OP_SUB: state_d = S_X_MAR;
          default:                          state_d = S_F_MAR;
        endcase
      end
      S_X_MAR: begin
        ctl.mar_from_cir = 1'b1;
        state_d = (opcode == OP_STORE) ? S_X_MDR : S_X_RD;
      end
      S_X_RD:  begin ctl.rd           = 1'b1; state_d = S_X_CAP; end
      S_X_CAP: begin ctl.mdr_from_mem = 1'b1; state_d = S_X_ALU; end
      S_X_ALU: begin
        ctl.acc_load = 1'b1;
        case (opcode)
          OP_ADD:  ctl.alu_op = ALU_ADD;
          OP_SUB:  ctl.alu_op = ALU_SUB;
          default: ctl.alu_op = ALU_PASS;
        endcase
        state_d = S_F_MAR;
      end
      S_X_MDR: begin ctl.mdr_from_acc = 1'b1; state_d = S_X_WR;  end
      S_X_WR:  begin ctl.wr           = 1'b1; state_d = S_F_MAR; end
      S_HALT:  state_d = S_HALT;
      default: state_d = S_F_MAR;
    endcase
  end

  assign halted = (state_q == S_HALT);

  // R3: the two strobes are mutually exclusive
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.rd && ctl.wr));

  // R9: halt is sticky until reset
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath import acc_cpu_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] cir,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] alu_y;

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op(ctl.alu_op), .acc_in(acc), .opnd(mdr), .result(alu_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      cir <= '0;
      acc <= '0;
    end else begin
      if (ctl.mar_from_pc)       mar <= pc;
      else if (ctl.mar_from_cir) mar <= cir[ADDR_W-1:0];
      if (ctl.pc_inc)            pc  <= pc + ADDR_W'(1);
      if (ctl.mdr_from_mem)      mdr <= rdata;
      else if (ctl.mdr_from_acc) mdr <= acc;
      if (ctl.cir_load)          cir <= mdr;
      if (ctl.acc_load)          acc <= alu_y;
    end
  end

  // R2: the program counter only ever steps forward by one
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> (pc == $past(pc) + ADDR_W'(1)));

  // R2: the instruction register is filled only from the data register
  assert_cir_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cir != $past(cir)) |-> (cir == $past(mdr)));

  // R13: every read strobe is followed by a capture into the data register
  assert_rd_capture_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rd |=> ctl.mdr_from_mem);

  // R8: while writing, the staged data equals the accumulator
  assert_wr_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wr |-> (mdr == acc));
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core import acc_cpu_pkg::*; #(
  parameter  int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [ADDR_W-1:0] dbg_mar,
  output logic [DATA_W-1:0] dbg_mdr,
  output logic [DATA_W-1:0] dbg_cir,
  output logic [DATA_W-1:0] dbg_acc
);
  ctl_t              ctl;
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mdr, cir, acc;

  acc_cpu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .opcode(cir[DATA_W-1 -: OPC_W]),
    .ctl(ctl), .halted(halted)
  );

  acc_cpu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .rdata(mem_rdata),
    .pc(pc), .mar(mar), .mdr(mdr), .cir(cir), .acc(acc)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_rd    = ctl.rd;
  assign mem_wr    = ctl.wr;
  assign dbg_pc    = pc;
  assign dbg_mar   = mar;
  assign dbg_mdr   = mdr;
  assign dbg_cir   = cir;
  assign dbg_acc   = acc;

  // R11: the accumulator never moves straight off the read bus
  assert_acc_staged_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc != $past(acc)) |-> (!$past(mem_rd) && !$past(mem_rd, 2)));

  // R8: a write lasts one cycle and carries the accumulator
  assert_wr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  assert_wr_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata == acc));

  // R9: a halted machine is quiet and frozen
  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));
  assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(acc) && $stable(pc) && $stable(mar) && $stable(mdr)));
endmodule

// File: tb/acc_cpu_core_test.sv
module acc_cpu_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr, dbg_pc, dbg_mar;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] mem_wdata, mem_rdata, dbg_mdr, dbg_cir, dbg_acc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] ram [4096];
  logic [15:0] ref_mem [4096];

  always #5 clk = ~clk;

  acc_cpu_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .dbg_pc(dbg_pc), .dbg_mar(dbg_mar),
    .dbg_mdr(dbg_mdr), .dbg_cir(dbg_cir), .dbg_acc(dbg_acc)
  );

  // synchronous single-port memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_wr) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // R3 every cycle: address is the address register, strobes exclusive
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3", "addr==mar", {20'd0, mem_addr}, {20'd0, dbg_mar});
      check("R3", "strobe overlap", {31'd0, mem_rd & mem_wr}, 32'd0);
      if (halted) check("R9", "strobes in halt", {30'd0, mem_rd, mem_wr}, 32'd0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog expired actual=hung expected=halt");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] word(input int op, input int a);
    return {op[3:0], a[11:0]};
  endfunction

  initial begin
    logic [15:0] w, acc_m, exp_mdr;
    logic [11:0] pc_m, exp_mar, a;
    logic [3:0]  op;
    int          cyc;
    bit          stop;

    // program image
    for (int i = 0; i < 4096; i++) ref_mem[i] = 16'h0000;
    for (int i = 0; i < 50; i++) ref_mem[i] = word(5 + (i % 11), i * 7); // R10 fillers
    ref_mem[50] = word(3, 101);  // ADD 101
    ref_mem[51] = word(1, 200);  // LOAD 200
    ref_mem[52] = word(3, 201);  // ADD 201
    ref_mem[53] = word(4, 202);  // SUB 202
    ref_mem[54] = word(2, 300);  // STORE 300
    ref_mem[55] = word(1, 101);  // LOAD 101
    ref_mem[56] = word(1, 300);  // LOAD 300
    ref_mem[57] = word(2, 58);   // STORE 58: overwrite the halt below
    ref_mem[58] = word(0, 0);    // HALT, replaced by a no-op word
    ref_mem[59] = word(1, 203);  // LOAD 203
    ref_mem[60] = word(0, 0);    // HALT
    ref_mem[101] = 16'd96;
    ref_mem[200] = 16'hFFF0;
    ref_mem[201] = 16'h0025;
    ref_mem[202] = 16'h0020;
    ref_mem[203] = 16'h1234;
    for (int i = 0; i < 4096; i++) ram[i] <= ref_mem[i];
    mem_rdata <= 16'h0000;

    repeat (3) @(negedge clk);
    check("R1", "pc", {20'd0, dbg_pc}, 0);
    check("R1", "acc", {16'd0, dbg_acc}, 0);
    check("R1", "mdr|cir|mar", {dbg_mdr | dbg_cir, 4'd0, dbg_mar}, 0);
    check("R1", "strobes+halt", {29'd0, mem_rd, mem_wr, halted}, 0);
    rst_n = 1'b1;

    pc_m = '0; acc_m = '0; stop = 1'b0;
    for (int n = 0; n < 200 && !stop; n++) begin
      w = ref_mem[pc_m]; op = w[15:12]; a = w[11:0];
      cyc = 6; exp_mar = pc_m; exp_mdr = w;
      pc_m = pc_m + 12'd1;
      case (op)
        4'd0: stop = 1'b1;
        4'd1: begin acc_m = ref_mem[a]; cyc += 4; exp_mar = a; exp_mdr = ref_mem[a]; end
        4'd3: begin acc_m = acc_m + ref_mem[a]; cyc += 4; exp_mar = a; exp_mdr = ref_mem[a]; end
        4'd4: begin acc_m = acc_m - ref_mem[a]; cyc += 4; exp_mar = a; exp_mdr = ref_mem[a]; end
        4'd2: begin ref_mem[a] = acc_m; cyc += 3; exp_mar = a; exp_mdr = acc_m; end
        default: ;
      endcase
      repeat (cyc) @(posedge clk);
      @(negedge clk);
      check("R2", "pc", {20'd0, dbg_pc}, {20'd0, pc_m});
      check("R2", "cir", {16'd0, dbg_cir}, {16'd0, w});
      check("R4", "mar", {20'd0, dbg_mar}, {20'd0, exp_mar});
      check("R11", "mdr", {16'd0, dbg_mdr}, {16'd0, exp_mdr});
      case (op)
        4'd1: check("R5", "acc after load", {16'd0, dbg_acc}, {16'd0, acc_m});
        4'd2: check("R8", "acc after store", {16'd0, dbg_acc}, {16'd0, acc_m});
        4'd3: check("R6", "acc after add", {16'd0, dbg_acc}, {16'd0, acc_m});
        4'd4: check("R7", "acc after sub", {16'd0, dbg_acc}, {16'd0, acc_m});
        4'd0: check("R9", "halt flag", {31'd0, halted}, 1);
        default: check("R10", "acc after no-op", {16'd0, dbg_acc}, {16'd0, acc_m});
      endcase
      if (op != 4'd0) check("R13", "not halted", {31'd0, halted}, 0);
      if (n == 50) begin // trace: word 50 is ADD 101
        check("R12", "pc", {20'd0, dbg_pc}, 51);
        check("R12", "mar", {20'd0, dbg_mar}, 101);
        check("R12", "mdr", {16'd0, dbg_mdr}, 96);
        check("R12", "acc", {16'd0, dbg_acc}, 96);
      end
      if (n == 52) check("R6", "wrap 0xFFF0+0x25", {16'd0, dbg_acc}, 32'h0015);
      if (n == 53) check("R7", "wrap 0x15-0x20", {16'd0, dbg_acc}, 32'hFFF5);
    end
    check("R8", "halt reached at 60", {20'd0, dbg_pc}, 61);
    check("R5", "final acc", {16'd0, dbg_acc}, 32'h1234);
    check("R8", "ram[300]", {16'd0, ram[300]}, 32'hFFF5);
    check("R8", "ram[58] self-modified", {16'd0, ram[58]}, 32'hFFF5);

    repeat (20) @(negedge clk);
    check("R9", "still halted", {31'd0, halted}, 1);
    check("R9", "pc frozen", {20'd0, dbg_pc}, 61);
    check("R9", "acc frozen", {16'd0, dbg_acc}, 32'h1234);

    done = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R1", "pc after reset", {20'd0, dbg_pc}, 0);
    check("R1", "acc after reset", {16'd0, dbg_acc}, 0);
    check("R1", "halt after reset", {31'd0, halted}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule